// File: doc/BRIEF.md
# Binary-Tree Piecewise-Affine Evaluator

This block evaluates a piecewise-affine vector function over an irregular partition of a scaled input box. After a start pulse it latches an N-component input vector. It then walks a binary decision tree held in parameters, beginning at node 0. At each internal node it tests the sign of that node's affine boundary at the input point and moves to one of two children. When it reaches a leaf, it takes that leaf's region number. It then evaluates the region's affine law for each of the M output components and raises a one-cycle completion flag.

A single multiply-accumulate datapath serves both the boundary tests and the output evaluation. It handles one coefficient per cycle. The latency therefore depends on how deep the visited leaf lies. The tree topology, the boundary coefficients and the per-region output coefficients are supplied by parameters. Building the tree is done offline and is not part of this block.

Top module: `pwa_tree_eval`

## Requirements
- R1: After reset, `done` is 0, `y` is all zeros and the block is idle.
- R2: Input component i is `x[i*XW +: XW]`. It is signed two's complement with FRAC fraction bits, so its value is code/2^FRAC and it lies in [-1, 1). The vector is captured only in the cycle in which a start is accepted.
- R3: Node k carries a leaf flag `NLEAF[k]` and child fields `NLEFT[k*IW +: IW]` and `NRIGHT[k*IW +: IW]`. Coefficient i of node k is `NCOEF[(k*(N+1)+i)*CW +: CW]`, where i = N is the offset. All coefficients are signed with FRAC fraction bits. At an internal node the boundary value is sum(a_i*x_i) + c. When this value is >= 0, including exactly 0, the walk moves to the right child; otherwise it moves to the left child. The walk starts at node 0.
- R4: At a leaf, `NRIGHT` holds the region index r. Output component o equals floor(sum(f_i*x_i) + g) taken at FRAC fraction bits, so it uses the same scaling as the inputs. Its coefficient i is `RCOEF[((r*M+o)*(N+1)+i)*CW +: CW]`, where i = N is g. The output is placed in `y[o*OW +: OW]`.
- R5: Each output component saturates to the signed OW-bit range instead of wrapping.
- R6: `done` is high for exactly one cycle. It rises D*(N+2) + M*(N+2) + 1 clock edges after the edge that accepted the start, where D is the number of internal nodes visited.
- R7: A start asserted while a computation is in progress is ignored. The running result, its timing and the captured input are unaffected.
- R8: While the block is idle, `y` holds its last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| x | input | N*XW | Packed signed input vector |
| done | output | 1 | One-cycle pulse when all outputs are valid |
| y | output | M*OW | Packed signed saturated output vector |

## Verification
The hardest case to reach from the ports is a point lying exactly on a boundary, where the boundary value is zero and the walk must take the right branch. Random inputs almost never land there, so directed points are placed exactly on the test tree's boundaries, including a diagonal one. Every region is reached, so the walk depth changes. The bench predicts the latency for each depth and checks it. Inputs that drive the affine sums past the output range check saturation in both directions, and a second start injected mid-walk checks that the block ignores it.

// File: rtl/pwa_tree_eval.sv
module pwa_tree_eval #(
  parameter int N = 2,
  parameter int M = 2,
  parameter int XW = 12,
  parameter int CW = 16,
  parameter int OW = 16,
  parameter int FRAC = 11,
  parameter int NODES = 7,
  parameter int REGIONS = 4,
  localparam int IW = $clog2((NODES > REGIONS) ? NODES : ((REGIONS > 2) ? REGIONS : 2)),
  parameter logic [NODES-1:0] NLEAF = '1,
  parameter logic [NODES*IW-1:0] NLEFT = '0,
  parameter logic [NODES*IW-1:0] NRIGHT = '0,
  parameter logic [NODES*(N+1)*CW-1:0] NCOEF = '0,
  parameter logic [REGIONS*M*(N+1)*CW-1:0] RCOEF = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N*XW-1:0] x,
  output logic            done,
  output logic [M*OW-1:0] y
);
  localparam int KW = $clog2(N + 2);
  localparam int OIW = (M > 1) ? $clog2(M) : 1;
  localparam int ACCW = XW + CW + $clog2(N + 1) + 2;
  localparam logic signed [ACCW-1:0] YMAX = ACCW'((longint'(1) <<< (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] YMIN = -YMAX - 1;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_EVAL} st_t;

  st_t st;
  logic [N*XW-1:0] xr;
  logic [IW-1:0] node, region;
  logic [KW-1:0] k;
  logic [OIW-1:0] o;
  logic signed [ACCW-1:0] acc, term, sum, sh;
  logic signed [CW-1:0] cf;
  logic signed [XW-1:0] xs;
  logic [OW-1:0] sat;
  logic [M*OW-1:0] y_r;
  logic done_r;

  always_comb begin
    int kc, ci;
    kc = (int'(k) > N) ? N : int'(k);
    if (st == S_EVAL) begin
      ci = ((int'(region) * M + int'(o)) * (N + 1) + kc) * CW;
      cf = RCOEF[ci +: CW];
    end else begin
      ci = (int'(node) * (N + 1) + kc) * CW;
      cf = NCOEF[ci +: CW];
    end
    xs = xr[((kc < N) ? kc : 0) * XW +: XW];
    term = (kc == N) ? (ACCW'(cf) <<< FRAC) : ACCW'(cf) * ACCW'(xs);
    sum = acc + term;
    sh = acc >>> FRAC;
    if (sh > YMAX) sat = OW'(YMAX);
    else if (sh < YMIN) sat = OW'(YMIN);
    else sat = OW'(sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      xr <= '0;
      node <= '0;
      region <= '0;
      k <= '0;
      o <= '0;
      acc <= '0;
      y_r <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          xr <= x;
          node <= '0;
          k <= '0;
          acc <= '0;
          st <= S_WALK;
        end
        S_WALK: begin
          if (k == '0 && NLEAF[node]) begin
            region <= NRIGHT[node*IW +: IW];
            o <= '0;
            st <= S_EVAL;
          end else if (int'(k) <= N) begin
            acc <= sum;
            k <= k + KW'(1);
          end else begin
            node <= acc[ACCW-1] ? NLEFT[node*IW +: IW] : NRIGHT[node*IW +: IW];
            acc <= '0;
            k <= '0;
          end
        end
        S_EVAL: begin
          if (int'(k) <= N) begin
            acc <= sum;
            k <= k + KW'(1);
          end else begin
            y_r[o*OW +: OW] <= sat;
            acc <= '0;
            k <= '0;
            if (int'(o) == M - 1) begin
              done_r <= 1'b1;
              st <= S_IDLE;
            end else begin
              o <= o + OIW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done = done_r;
  assign y = y_r;
endmodule

// File: rtl/pwa_tree_eval_chk.sv
module pwa_tree_eval_chk #(
  parameter int XRW = 24,
  parameter int YW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic           busy,
  input logic [XRW-1:0] xr,
  input logic [YW-1:0]  y
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xr));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(y));
endmodule

bind pwa_tree_eval pwa_tree_eval_chk #(.XRW(N*XW), .YW(M*OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .busy(st != S_IDLE), .xr(xr), .y(y)
);

// File: tb/pwa_tree_eval_tb_top.sv
module pwa_tree_eval_tb_top;
  localparam int PERIOD = 10;
  localparam int TN = 7;
  localparam int TR = 4;

  localparam int NC[TN][3] = '{'{2048,0,0}, '{0,0,0}, '{2048,2048,-1024}, '{0,0,0},
                               '{0,2048,0}, '{0,0,0}, '{0,0,0}};
  localparam int LF[TN] = '{0,1,0,1,0,1,1};
  localparam int LL[TN] = '{1,0,3,0,5,0,0};
  localparam int LR[TN] = '{2,0,4,1,6,2,3};
  localparam int RC[TR][2][3] = '{
    '{'{1024,512,2048}, '{-6144,0,-256}},
    '{'{32000,30720,30720}, '{-32768,0,0}},
    '{'{2048,0,0}, '{0,2048,0}},
    '{'{-30720,-30720,-30720}, '{4096,-2048,0}}};

  function automatic logic [TN*3*16-1:0] pk_nc();
    logic [TN*3*16-1:0] r;
    r = '0;
    for (int n = 0; n < TN; n++)
      for (int i = 0; i < 3; i++) r[(n*3+i)*16 +: 16] = 16'(NC[n][i]);
    return r;
  endfunction

  function automatic logic [TR*2*3*16-1:0] pk_rc();
    logic [TR*2*3*16-1:0] r;
    r = '0;
    for (int g = 0; g < TR; g++)
      for (int o = 0; o < 2; o++)
        for (int i = 0; i < 3; i++) r[((g*2+o)*3+i)*16 +: 16] = 16'(RC[g][o][i]);
    return r;
  endfunction

  function automatic logic [TN*3-1:0] pk_idx(input bit right);
    logic [TN*3-1:0] r;
    r = '0;
    for (int n = 0; n < TN; n++) r[n*3 +: 3] = 3'(right ? LR[n] : LL[n]);
    return r;
  endfunction

  function automatic logic [TN-1:0] pk_leaf();
    logic [TN-1:0] r;
    for (int n = 0; n < TN; n++) r[n] = LF[n][0];
    return r;
  endfunction

  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] x = '0;
  logic done;
  logic [31:0] y;
  int n_run = 0, n_fail = 0;
  bit ended = 0;

  pwa_tree_eval #(
    .N(2), .M(2), .XW(12), .CW(16), .OW(16), .FRAC(11), .NODES(TN), .REGIONS(TR),
    .NLEAF(pk_leaf()), .NLEFT(pk_idx(1'b0)), .NRIGHT(pk_idx(1'b1)),
    .NCOEF(pk_nc()), .RCOEF(pk_rc())
  ) dut_i (.clk(clk), .rst_n(rst_n), .start(start), .x(x), .done(done), .y(y));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_eval(input int a0, input int a1, output int d,
                                   output int y0, output int y1);
    int nd, g;
    longint v;
    int yo[2];
    nd = 0; d = 0;
    while (LF[nd] == 0) begin
      v = longint'(NC[nd][0])*a0 + longint'(NC[nd][1])*a1 + longint'(NC[nd][2])*2048;
      nd = (v >= 0) ? LR[nd] : LL[nd];
      d++;
    end
    g = LR[nd];
    for (int o = 0; o < 2; o++) begin
      v = longint'(RC[g][o][0])*a0 + longint'(RC[g][o][1])*a1 + longint'(RC[g][o][2])*2048;
      v = v >>> 11;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      yo[o] = int'(v);
    end
    y0 = yo[0]; y1 = yo[1];
  endfunction

  task automatic run(input int a0, input int a1, input bit inject);
    int d, e0, e1, lat, cnt;
    ref_eval(a0, a1, d, e0, e1);
    lat = d*4 + 2*4 + 1;
    x = {12'(a1), 12'(a0)};
    start = 1;
    @(posedge clk); #1;
    start = 0;
    cnt = 0;
    while (!done && cnt < 100) begin
      if (inject && cnt == 3) begin
        x = {12'(-a1 - 1), 12'(-a0 - 1)};
        start = 1;
      end
      @(posedge clk); #1;
      start = 0;
      cnt++;
    end
    chk(cnt == lat, inject ? "R7 latency with busy start" : "R6 done latency", cnt, lat);
    chk($signed(y[15:0]) == e0, "R4/R5 y0", $signed(y[15:0]), e0);
    chk($signed(y[31:16]) == e1, "R4/R5 y1", $signed(y[31:16]), e1);
    @(posedge clk); #1;
    chk(done == 0, "R6 done single cycle", done, 0);
  endtask

  initial begin
    logic [31:0] yh;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    chk(done == 0, "R1 done after reset", done, 0);
    chk(y == '0, "R1 y after reset", y, 0);
    rst_n = 1;
    @(posedge clk); #1;
    // R3 ties: boundary value exactly zero goes right
    run(0, 0, 0);
    run(-1, 0, 0);
    run(1024, 0, 0);
    run(512, 512, 0);
    run(1024, -1, 0);
    run(2047, 2047, 0);
    run(-2048, -2048, 0);
    run(2047, -2048, 0);
    run(0, 1024, 0);
    // R7: second start while busy is ignored
    run(300, -700, 1);
    run(1500, 900, 1);
    // R8: outputs hold while idle and inputs change
    yh = y;
    repeat (6) begin
      x = 24'($urandom);
      @(posedge clk); #1;
    end
    chk(y == yh, "R8 y held when idle", y, yh);
    chk(done == 0, "R8 no done when idle", done, 0);
    // R2: random full-range inputs
    for (int t = 0; t < 80; t++) begin
      int a0, a1;
      a0 = int'($signed(12'($urandom)));
      a1 = int'($signed(12'($urandom)));
      run(a0, a1, (t % 9) == 4);
    end
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!ended) begin
      ended = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule